// File: doc/BRIEF.md
# Dual-Group Invertible GPIO Bank

This block controls sixteen general-purpose pins organised as two groups of eight. Every pin has three control bits: a direction bit, a data bit and an inversion bit. The inversion bit applies in both directions. On an output it flips the value sent to the pin. On an input it flips the value read back from the pin. Input pins pass through a two-flop synchronizer before inversion and readback.

Software programs the bank through a simple index/write/read configuration port. The direction and data registers of both groups can also be reached through a four-byte I/O window placed at a programmable base address. Each group is switched on by a shared master enable bit or by its own enable bit. A per-group ownership input must also be high, because the pins may be lent to another function.

Output drive is open-drain on every pin except pin 0 of group 1, which drives push-pull. The block presents per-pin drive and output-enable signals and leaves pad electrical behaviour to the pad ring.

Top module: `dual_gpio_bank`

## Requirements
- R1: A synchronous active-high reset sets the registers as follows: both direction registers to FFh, and both data registers, both inversion registers, the enable register and both base-address registers to 00h. After reset no pad output enable is asserted.
- R2: A direction bit of 1 makes its pin an input and 0 makes it an output. Bit n of every group register maps to pin n of that group, and group 2 occupies `pad_*[15:8]`.
- R3: An output pin drives data XOR inversion. A read of the data register returns the stored data bit, not inverted, for every output pin.
- R4: A read of the data register returns pin XOR inversion for every input pin. The pin value is visible two rising clock edges after it changes at the pad.
- R5: Every pin other than group 1 pin 0 is open-drain. When its driven value is 0 it asserts `pad_oe` with `pad_out` 0. When its driven value is 1 it deasserts `pad_oe`.
- R6: Group 1 pin 0 is push-pull. As an enabled output it always asserts `pad_oe`, and `pad_out` equals its driven value.
- R7: Group g (g = 1, 2) is active when `pin_own[g-1]` is 1 and either bit 0 or bit g of the enable register is 1. An inactive group asserts no `pad_oe` and reads 00h from its data register.
- R8: The configuration indices are:
  - 30h: enable register, bits 2:0 only, reading 0 above bit 2.
  - 60h / 61h: base address high / low byte.
  - F0h / F1h / F2h: group 1 direction / data / inversion.
  - F3h / F4h / F5h: the same three registers for group 2.

  Any other index reads 00h. A configuration write takes effect at the next rising edge, and reads are combinational.
- R9: The window base is {60h, 61h} with its two low bits forced to 0, and 61h reads back with bits 1:0 clear. The window offsets are:
  - base+0: group 1 direction.
  - base+1: group 1 data.
  - base+2: group 2 direction.
  - base+3: group 2 data.

  A decoded access raises `io_hit`. Its read data is combinational, and its write lands at the next edge.
- R10: The window decodes only when the base lies in 0100h–0FF8h and the addressed group is active. Otherwise `io_hit` is 0, `io_rdata` is 00h and writes are ignored.
- R11: When a configuration write and a window write target the same register in the same cycle, the configuration write wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_idx | input | 8 | Configuration register index |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read data for `cfg_idx` |
| io_addr | input | 16 | I/O window address |
| io_we | input | 1 | I/O window write strobe |
| io_wdata | input | 8 | I/O window write data |
| io_rdata | output | 8 | I/O window read data |
| io_hit | output | 1 | I/O address decoded by the window |
| pin_own | input | 2 | Per-group pin ownership from the pin multiplexer |
| pad_in | input | 16 | Pin input values, group 2 in the upper byte |
| pad_out | output | 16 | Pin drive values |
| pad_oe | output | 16 | Pin output enables |

## Verification
The hardest case to reach is the same-cycle collision between a configuration write and a window write to one data register. Getting there requires a valid window base, an active group and both strobes raised on the same clock edge. The bench programs the base first and then drives both strobes from one stimulus step before reading the register back.

A second hard case is the synchronizer latency. To observe it, the pin is changed on a falling edge and the data register is sampled after exactly one and after exactly two rising edges.

// File: rtl/gpb_pkg.sv
package gpb_pkg;

    localparam int GRP_W  = 8;
    localparam int N_GRP  = 2;
    localparam int PIN_W  = GRP_W * N_GRP;
    localparam int ADDR_W = 16;

    typedef logic [GRP_W-1:0]  byte_t;
    typedef logic [ADDR_W-1:0] addr_t;

    localparam byte_t IDX_ENABLE  = 8'h30;
    localparam byte_t IDX_BASE_HI = 8'h60;
    localparam byte_t IDX_BASE_LO = 8'h61;
    localparam byte_t IDX_GRP0    = 8'hF0;

    localparam addr_t WIN_MIN = 16'h0100;
    localparam addr_t WIN_MAX = 16'h0FF8;

    // field order within a group's three configuration indices
    typedef enum int {FLD_DIR = 0, FLD_DAT = 1, FLD_INV = 2} grp_fld_e;

    // window offsets: bit 1 picks the group, bit 0 picks data over direction
    typedef enum logic [1:0] {
        WIN_DIR1 = 2'd0,
        WIN_DAT1 = 2'd1,
        WIN_DIR2 = 2'd2,
        WIN_DAT2 = 2'd3
    } win_reg_e;

    typedef struct packed {
        logic  dir_we;
        byte_t dir_wd;
        logic  dat_we;
        byte_t dat_wd;
        logic  inv_we;
        byte_t inv_wd;
    } grp_wr_t;

    function automatic byte_t grp_idx(input int g, input grp_fld_e f);
        return IDX_GRP0 + byte_t'(3 * g + int'(f));
    endfunction

endpackage

// File: rtl/gpb_sync.sv
module gpb_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] s1_q;
    logic [W-1:0] s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d;
            s2_q <= s1_q;
        end
    end

    assign q = s2_q;
endmodule

// File: rtl/gpb_group.sv
module gpb_group
    import gpb_pkg::*;
#(
    parameter logic [GRP_W-1:0] PP_MASK = '0
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  grp_wr_t wr,
    input  byte_t   pad_in,
    output byte_t   pad_out,
    output byte_t   pad_oe,
    output byte_t   dir_q,
    output byte_t   inv_q,
    output byte_t   dat_rd
);
    byte_t dat_q;
    byte_t pin_sync;
    byte_t drive;
    byte_t in_val;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= '1;
            dat_q <= '0;
            inv_q <= '0;
        end else begin
            if (wr.dir_we) dir_q <= wr.dir_wd;
            if (wr.dat_we) dat_q <= wr.dat_wd;
            if (wr.inv_we) inv_q <= wr.inv_wd;
        end
    end

    gpb_sync #(.W(GRP_W)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pin_sync)
    );

    assign drive  = dat_q ^ inv_q;
    assign in_val = pin_sync ^ inv_q;
    assign dat_rd = active ? ((dir_q & in_val) | (~dir_q & dat_q)) : '0;

    for (genvar i = 0; i < GRP_W; i++) begin : g_bit
        if (PP_MASK[i]) begin : g_pp
            assign pad_oe[i]  = active & ~dir_q[i];
            assign pad_out[i] = active & ~dir_q[i] & drive[i];
        end else begin : g_od
            assign pad_oe[i]  = active & ~dir_q[i] & ~drive[i];
            assign pad_out[i] = 1'b0;
        end
    end

    // cycles since reset, saturating, so the latency check never looks before reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (dir_q == '1 && inv_q == '0 && pad_oe == '0));

    assert_idle_group_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !active |-> (pad_oe == '0 && dat_rd == '0));

    assert_input_latency_R4: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && active) |->
            (((dat_rd ^ $past(pad_in, 2) ^ inv_q) & dir_q) == '0));

    assert_od_release_R5: assert property (@(posedge clk) disable iff (rst)
        (active && !dir_q[GRP_W-1] && !PP_MASK[GRP_W-1] && drive[GRP_W-1])
            |-> !pad_oe[GRP_W-1]);
endmodule

// File: rtl/gpb_window.sv
module gpb_window
    import gpb_pkg::*;
(
    input  byte_t            base_hi,
    input  logic [GRP_W-1:2] base_lo,
    input  addr_t            io_addr,
    input  logic [N_GRP-1:0] grp_act,
    output logic             hit,
    output win_reg_e         sel
);
    addr_t base;
    logic  in_range;
    logic  match;

    assign base     = {base_hi, base_lo, 2'b00};
    assign in_range = (base >= WIN_MIN) && (base <= WIN_MAX);
    assign match    = io_addr[ADDR_W-1:2] == base[ADDR_W-1:2];
    assign sel      = win_reg_e'(io_addr[1:0]);
    assign hit      = in_range && match && grp_act[io_addr[1]];
endmodule

// File: rtl/dual_gpio_bank.sv
module dual_gpio_bank
    import gpb_pkg::*;
#(
    parameter logic [GRP_W-1:0] PP_MASK_G1 = 8'h01,
    parameter logic [GRP_W-1:0] PP_MASK_G2 = 8'h00
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       cfg_idx,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic [15:0]      io_addr,
    input  logic             io_we,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    output logic             io_hit,
    input  logic [1:0]       pin_own,
    input  logic [15:0]      pad_in,
    output logic [15:0]      pad_out,
    output logic [15:0]      pad_oe
);
    localparam logic [PIN_W-1:0] PP_ALL = {PP_MASK_G2, PP_MASK_G1};

    logic [N_GRP:0]   en_q;
    byte_t            base_hi_q;
    logic [GRP_W-1:2] base_lo_q;
    logic [N_GRP-1:0] grp_act;
    win_reg_e         win_sel;

    byte_t   dir_q  [N_GRP];
    byte_t   inv_q  [N_GRP];
    byte_t   dat_rd [N_GRP];
    grp_wr_t wr     [N_GRP];

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q      <= '0;
            base_hi_q <= '0;
            base_lo_q <= '0;
        end else if (cfg_we) begin
            if (cfg_idx == IDX_ENABLE)  en_q      <= cfg_wdata[N_GRP:0];
            if (cfg_idx == IDX_BASE_HI) base_hi_q <= cfg_wdata;
            if (cfg_idx == IDX_BASE_LO) base_lo_q <= cfg_wdata[GRP_W-1:2];
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_act
        assign grp_act[g] = pin_own[g] & (en_q[0] | en_q[g+1]);
    end

    gpb_window u_win (
        .base_hi (base_hi_q),
        .base_lo (base_lo_q),
        .io_addr (io_addr),
        .grp_act (grp_act),
        .hit     (io_hit),
        .sel     (win_sel)
    );

    // merge both write paths; the configuration port takes priority
    always_comb begin
        for (int g = 0; g < N_GRP; g++) begin
            logic cfg_dir, cfg_dat, io_dir, io_dat;
            cfg_dir = cfg_we && cfg_idx == grp_idx(g, FLD_DIR);
            cfg_dat = cfg_we && cfg_idx == grp_idx(g, FLD_DAT);
            io_dir  = io_we && io_hit && win_sel[1] == g[0] && !win_sel[0];
            io_dat  = io_we && io_hit && win_sel[1] == g[0] &&  win_sel[0];
            wr[g].dir_we = cfg_dir | io_dir;
            wr[g].dir_wd = cfg_dir ? cfg_wdata : io_wdata;
            wr[g].dat_we = cfg_dat | io_dat;
            wr[g].dat_wd = cfg_dat ? cfg_wdata : io_wdata;
            wr[g].inv_we = cfg_we && cfg_idx == grp_idx(g, FLD_INV);
            wr[g].inv_wd = cfg_wdata;
        end
    end

    for (genvar g = 0; g < N_GRP; g++) begin : g_grp
        gpb_group #(.PP_MASK(PP_ALL[g*GRP_W +: GRP_W])) u_grp (
            .clk     (clk),
            .rst     (rst),
            .active  (grp_act[g]),
            .wr      (wr[g]),
            .pad_in  (pad_in[g*GRP_W +: GRP_W]),
            .pad_out (pad_out[g*GRP_W +: GRP_W]),
            .pad_oe  (pad_oe[g*GRP_W +: GRP_W]),
            .dir_q   (dir_q[g]),
            .inv_q   (inv_q[g]),
            .dat_rd  (dat_rd[g])
        );
    end

    always_comb begin
        cfg_rdata = '0;
        if (cfg_idx == IDX_ENABLE)  cfg_rdata = byte_t'(en_q);
        if (cfg_idx == IDX_BASE_HI) cfg_rdata = base_hi_q;
        if (cfg_idx == IDX_BASE_LO) cfg_rdata = {base_lo_q, 2'b00};
        for (int g = 0; g < N_GRP; g++) begin
            if (cfg_idx == grp_idx(g, FLD_DIR)) cfg_rdata = dir_q[g];
            if (cfg_idx == grp_idx(g, FLD_DAT)) cfg_rdata = dat_rd[g];
            if (cfg_idx == grp_idx(g, FLD_INV)) cfg_rdata = inv_q[g];
        end
    end

    always_comb begin
        io_rdata = '0;
        if (io_hit) begin
            case (win_sel)
                WIN_DIR1: io_rdata = dir_q[0];
                WIN_DAT1: io_rdata = dat_rd[0];
                WIN_DIR2: io_rdata = dir_q[1];
                WIN_DAT2: io_rdata = dat_rd[1];
                default:  io_rdata = '0;
            endcase
        end
    end

    assert_window_needs_active_R10: assert property (@(posedge clk) disable iff (rst)
        io_hit |-> grp_act[io_addr[1]]);

    assert_window_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !io_hit |-> io_rdata == '0);
endmodule

// File: tb/dual_gpio_bank_tb.sv
module dual_gpio_bank_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  cfg_idx = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [15:0] io_addr = '0;
    logic        io_we = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_hit;
    logic [1:0]  pin_own = 2'b11;
    logic [15:0] pad_in = '0;
    logic [15:0] pad_out;
    logic [15:0] pad_oe;

    int  vectors = 0;
    int  miscompares = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    dual_gpio_bank u_dut (
        .clk(clk), .rst(rst),
        .cfg_idx(cfg_idx), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .io_addr(io_addr), .io_we(io_we), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_hit(io_hit), .pin_own(pin_own), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    // group 1 vectors: dir, inv, dat, pin, expected oe, out, data readback
    typedef struct packed {
        logic [7:0] dir, inv, dat, pin, e_oe, e_out, e_rd;
    } vec_t;
    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{8'hFF, 8'h00, 8'h00, 8'hA5, 8'h00, 8'h00, 8'hA5},
        '{8'hFF, 8'h0F, 8'h00, 8'hA5, 8'h00, 8'h00, 8'hAA},
        '{8'h00, 8'h00, 8'h5A, 8'h00, 8'hA5, 8'h00, 8'h5A},
        '{8'h00, 8'hFF, 8'h5A, 8'h00, 8'h5B, 8'h01, 8'h5A},
        '{8'hF0, 8'h00, 8'h03, 8'h3C, 8'h0D, 8'h01, 8'h33},
        '{8'h0F, 8'h30, 8'hC0, 8'h81, 8'h00, 8'h00, 8'hC1},
        '{8'h00, 8'hAA, 8'hAA, 8'hFF, 8'hFF, 8'h00, 8'hAA}
    };

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic cfg_wr(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        cfg_idx = idx; cfg_wdata = d; cfg_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [7:0] idx, output logic [7:0] d);
        @(negedge clk);
        cfg_idx = idx;
        #1 d = cfg_rdata;
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_we = 1'b1;
        @(negedge clk);
        io_we = 1'b0;
    endtask

    task automatic io_rd(input logic [15:0] a, output logic [7:0] d, output logic h);
        @(negedge clk);
        io_addr = a;
        #1 d = io_rdata; h = io_hit;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
        #1;
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            vectors++;
            miscompares++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rd;
        logic       h;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk("R1 pad_oe", pad_oe, 16'h0000);
        cfg_rd(8'hF0, rd); chk("R1 dir1", rd, 8'hFF);
        cfg_rd(8'hF3, rd); chk("R1 dir2", rd, 8'hFF);
        cfg_rd(8'hF2, rd); chk("R1 inv1", rd, 8'h00);
        cfg_rd(8'h30, rd); chk("R1 enable", rd, 8'h00);
        cfg_rd(8'h60, rd); chk("R1 base hi", rd, 8'h00);

        // R7 / R5: only group 2 enabled through its own bit
        cfg_wr(8'h30, 8'h04);
        cfg_wr(8'hF3, 8'h00);
        cfg_wr(8'hF4, 8'h01);
        cfg_wr(8'hF0, 8'h00);
        cfg_wr(8'hF1, 8'hFF);
        settle();
        chk("R5 g2 open-drain oe", pad_oe[15:8], 16'h00FE);
        chk("R5 g2 open-drain out", pad_out[15:8], 16'h0000);
        chk("R7 g1 disabled oe", pad_oe[7:0], 16'h0000);
        cfg_rd(8'hF1, rd); chk("R7 g1 disabled data", rd, 8'h00);
        cfg_wr(8'h30, 8'h02);
        settle();
        chk("R7 g2 disabled oe", pad_oe[15:8], 16'h0000);
        cfg_rd(8'hF4, rd); chk("R7 g2 disabled data", rd, 8'h00);
        chk("R6 push-pull oe", pad_oe[7:0], 16'h0001);
        chk("R6 push-pull out", pad_out[7:0], 16'h0001);
        @(negedge clk); pin_own = 2'b10; #1;
        chk("R7 ownership low", pad_oe[7:0], 16'h0000);
        @(negedge clk); pin_own = 2'b11;
        cfg_wr(8'h30, 8'h01);

        // vector table on group 1 (R2 R3 R4 R5 R6)
        for (int v = 0; v < NV; v++) begin
            cfg_wr(8'hF0, VEC[v].dir);
            cfg_wr(8'hF2, VEC[v].inv);
            cfg_wr(8'hF1, VEC[v].dat);
            @(negedge clk); pad_in[7:0] = VEC[v].pin;
            settle();
            chk("R2 R5 R6 pad_oe", pad_oe[7:0], VEC[v].e_oe);
            chk("R3 R6 pad_out", pad_out[7:0], VEC[v].e_out);
            cfg_rd(8'hF1, rd); chk("R3 R4 readback", rd, VEC[v].e_rd);
        end

        // R4 synchronizer latency
        cfg_wr(8'hF0, 8'hFF);
        cfg_wr(8'hF2, 8'h00);
        @(negedge clk); pad_in[7:0] = 8'h00; cfg_idx = 8'hF1;
        settle();
        @(negedge clk); pad_in[7:0] = 8'h3C;
        @(negedge clk); #1 chk("R4 one edge", cfg_rdata, 8'h00);
        @(negedge clk); #1 chk("R4 two edges", cfg_rdata, 8'h3C);
        cfg_wr(8'hF2, 8'hFF);
        cfg_rd(8'hF1, rd); chk("R4 inverted input", rd, 8'hC3);

        // R8 map details
        cfg_rd(8'h50, rd); chk("R8 unmapped", rd, 8'h00);
        cfg_wr(8'h30, 8'hF9);
        cfg_rd(8'h30, rd); chk("R8 enable width", rd, 8'h01);
        cfg_wr(8'hF5, 8'h0F);
        cfg_rd(8'hF5, rd); chk("R8 inv2", rd, 8'h0F);
        cfg_rd(8'hF2, rd); chk("R8 inv1 separate", rd, 8'hFF);

        // R9 window
        cfg_wr(8'hF2, 8'h00);
        cfg_wr(8'hF0, 8'h00);
        cfg_wr(8'hF3, 8'h0F);
        cfg_wr(8'hF4, 8'h50);
        cfg_wr(8'hF5, 8'h00);
        @(negedge clk); pad_in[15:8] = 8'h06;
        cfg_wr(8'h60, 8'h03);
        cfg_wr(8'h61, 8'h43);
        cfg_rd(8'h61, rd); chk("R9 base low bits", rd, 8'h40);
        io_wr(16'h0341, 8'h77);
        cfg_rd(8'hF1, rd); chk("R9 window data write", rd, 8'h77);
        io_rd(16'h0340, rd, h); chk("R9 dir1 hit", {15'd0, h}, 16'h0001);
        chk("R9 dir1 data", rd, 8'h00);
        io_rd(16'h0342, rd, h); chk("R9 dir2", rd, 8'h0F);
        io_rd(16'h0343, rd, h); chk("R9 data2", rd, 8'h56);
        io_rd(16'h0344, rd, h); chk("R10 outside window", {15'd0, h}, 16'h0000);

        // R11 same-cycle collision
        @(negedge clk);
        cfg_idx = 8'hF1; cfg_wdata = 8'h11; cfg_we = 1'b1;
        io_addr = 16'h0341; io_wdata = 8'h22; io_we = 1'b1;
        @(negedge clk);
        cfg_we = 1'b0; io_we = 1'b0;
        cfg_rd(8'hF1, rd); chk("R11 cfg wins", rd, 8'h11);

        // R10 disabled group and base range
        cfg_wr(8'h30, 8'h02);
        io_rd(16'h0342, rd, h); chk("R10 inactive group hit", {15'd0, h}, 16'h0000);
        chk("R10 inactive group data", rd, 8'h00);
        io_wr(16'h0342, 8'hFF);
        cfg_wr(8'h30, 8'h01);
        cfg_rd(8'hF3, rd); chk("R10 write ignored", rd, 8'h0F);
        cfg_wr(8'h60, 8'h00);
        cfg_wr(8'h61, 8'h50);
        io_rd(16'h0051, rd, h); chk("R10 base below range", {15'd0, h}, 16'h0000);
        cfg_wr(8'h60, 8'h10);
        cfg_wr(8'h61, 8'h00);
        io_rd(16'h1000, rd, h); chk("R10 base above range", {15'd0, h}, 16'h0000);
        cfg_wr(8'h60, 8'h0F);
        cfg_wr(8'h61, 8'hF8);
        io_rd(16'h0FF8, rd, h); chk("R9 top base hit", {15'd0, h}, 16'h0001);
        cfg_wr(8'h60, 8'h01);
        cfg_wr(8'h61, 8'h00);
        io_rd(16'h0101, rd, h); chk("R9 bottom base data", rd, 8'h11);

        done = 1'b1;
        finish_run();
    end
endmodule